// File: doc/BRIEF.md
# Four-Way Set-Associative Cache Controller

This block keeps tags, valid flags, modified flags and line data for a four-way set-associative cache placed between a 32-bit processor request port and a single-beat system-memory port. Each request address is split into a longword select, a set index and a tag. The four stored tags of the indexed set are compared in parallel and the per-way match vector selects the returned longword. A read hit answers in the cycle after the request is taken. A write hit updates the line in place.

Each write carries its own policy flag. A copyback write marks the line modified and makes no memory access. A write-through write is always forwarded to memory as one write beat. A read miss or a copyback write miss allocates a line. The allocation takes the lowest-numbered invalid way, or a shared rotating pointer when the whole set is valid. A modified victim is written back as four longwords before the new line is fetched as four longword reads. While any memory traffic is in progress the request port is held not ready.

Top module: `cache4w_ctrl`

## Requirements
- R1: After a synchronous active-low reset every line is invalid and unmodified, the rotating victim pointer is 0, `req_ready` is 1, and `resp_valid` and `mem_valid` are 0.
- R2: Address bits [3:2] select the longword, bits [SET_BITS+3:4] select the set and the bits above them form the tag. A way hits only if its tag equals the request tag and its valid flag is set. Lines in different sets never hit for each other.
- R3: A read hit gives `resp_valid`=1, `resp_hit`=1 and the addressed longword in the cycle after the request is accepted.
- R4: A copyback write hit (`req_wthru`=0) updates the addressed longword, marks the line modified, answers with `resp_hit`=1 in the next cycle and makes no memory access.
- R5: A write-through write (`req_wthru`=1) makes exactly one memory write of the request address and data, and answers after its acknowledge. On a hit it also updates the line and does not mark it modified. On a miss it allocates nothing.
- R6: A read miss or a copyback write miss fills the chosen way with four memory reads of longwords 0 to 3, stores the tag, sets valid and answers with `resp_hit`=0. A read returns the addressed longword. A copyback write merges its data and marks the line modified.
- R7: The victim is the lowest-numbered invalid way of the set. If all four ways are valid, the victim is given by one 2-bit pointer shared by all sets, and that pointer advances by one (wrapping 3 to 0) only when it chose a victim.
- R8: A victim that is valid and modified is first written to memory at its old address as four writes, longwords 0 to 3, before any refill read. A clean victim causes no writes.
- R9: `req_ready` is 0 while a writeback, refill or write-through is in progress. A memory request keeps `mem_valid` and `mem_addr` steady until it is acknowledged.
- R10: At most one way of a set hits at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wthru | input | 1 | Write policy: 1 = write-through, 0 = copyback |
| req_addr | input | ADDR_W | Byte address of the longword |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller can take a request this cycle |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_hit | output | 1 | Completed request hit in the cache |
| resp_rdata | output | DATA_W | Read data, valid with a read completion |
| mem_valid | output | 1 | Memory beat request |
| mem_write | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory longword address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory accepts or completes the current beat |
| mem_rdata | input | DATA_W | Memory read data, valid with the acknowledge |

## Verification
The bench builds the controller with SET_BITS=2, which gives four sets, and keeps four ways and four-longword lines. With so few sets, filling one set, evicting from a full set, wrapping the shared pointer and evicting a modified line all happen within a few dozen requests to a single set. A second set shows that sets are independent. The memory model and a reference image of memory are kept in the bench. The order of memory beats is logged for each request, so the writeback-before-refill order and the missing writes for clean victims can be checked.

// File: rtl/cache4w_pkg.sv
// Shared types for the four-way cache controller.
// Assumes: nothing beyond standard SystemVerilog.
package cache4w_pkg;
    // Controller sequencing states
    typedef enum logic [2:0] {
        ST_IDLE,   // lookup and accept requests
        ST_WB,     // write modified victim back
        ST_FILL,   // read new line from memory
        ST_FIN,    // finish allocation and answer
        ST_WT      // forward a write-through write
    } cstate_t;
endpackage

// File: rtl/cache4w_match.sv
// Parallel tag comparison for one set.
// Produces a per-way hit vector and the encoded index of the hitting way.
// Assumes at most one way matches (stored tags of a set are unique).
module cache4w_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 21,
    localparam int WAY_BITS = $clog2(WAYS)
) (
    input  logic [TAG_W-1:0]    way_tag [WAYS],
    input  logic [WAYS-1:0]     way_valid,
    input  logic [TAG_W-1:0]    req_tag,
    output logic [WAYS-1:0]     hit_vec,
    output logic [WAY_BITS-1:0] hit_way
);
    // One comparator per way
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == req_tag);
    end

    // Encode the hitting way into an index
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_BITS'(w);
        end
    end
endmodule

// File: rtl/cache4w_victim.sv
// Victim way choice for allocation.
// Takes the lowest invalid way; when the set is full, uses one rotating
// pointer shared by all sets, which advances only when it was used.
// Assumes alloc is asserted for one cycle per allocation.
module cache4w_victim #(
    parameter int WAYS = 4,
    localparam int WAY_BITS = $clog2(WAYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [WAYS-1:0]     valid_set,
    input  logic                alloc,
    output logic [WAY_BITS-1:0] victim
);
    logic [WAY_BITS-1:0] rr_ptr;
    logic [WAY_BITS-1:0] free_way;
    logic                set_full;

    assign set_full = &valid_set;

    // Lowest-numbered invalid way (scan downward so the lowest wins)
    always_comb begin
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_set[w]) free_way = WAY_BITS'(w);
        end
    end

    assign victim = set_full ? rr_ptr : free_way;

    // Rotate the pointer each time it picks a victim
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (alloc && set_full) begin
            rr_ptr <= rr_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/cache4w_ctrl.sv
// Four-way set-associative cache controller.
// Holds tag/valid/modified/data arrays, performs lookup, write hits,
// write-through forwarding, dirty writeback and line refill.
// Assumes: LINE_WORDS is a power of two, one request in flight at a time,
// memory holds mem_valid requests until mem_ack in the same cycle.
module cache4w_ctrl
    import cache4w_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int SET_BITS   = 7,
    parameter int WAYS       = 4,
    parameter int LINE_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wthru,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int WORD_BITS = $clog2(LINE_WORDS);
    localparam int OFF_BITS  = WORD_BITS + 2;
    localparam int TAG_W     = ADDR_W - SET_BITS - OFF_BITS;
    localparam int SETS      = 1 << SET_BITS;
    localparam int WAY_BITS  = $clog2(WAYS);
    localparam logic [WORD_BITS-1:0] LAST_BEAT = WORD_BITS'(LINE_WORDS - 1);

    // Storage arrays
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [WAYS-1:0]   valid_q [SETS];
    logic [WAYS-1:0]   dirty_q [SETS];
    logic [DATA_W-1:0] data_q  [SETS][WAYS][LINE_WORDS];

    // Request holding and sequencing state
    cstate_t             state;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic                write_q;
    logic [WAY_BITS-1:0] vway_q;
    logic [WORD_BITS-1:0] beat_q;

    // Lookup fields, taken from the port while idle, else from the held request
    logic [TAG_W-1:0]     cur_tag;
    logic [SET_BITS-1:0]  cur_set;
    logic [WORD_BITS-1:0] cur_word;
    logic [TAG_W-1:0]     way_tags [WAYS];
    logic [WAYS-1:0]      valid_set, dirty_set, hit_vec;
    logic [WAY_BITS-1:0]  hit_way, victim;
    logic                 lookup_hit, accept, alloc;

    // Field decode
    always_comb begin
        if (state == ST_IDLE) begin
            cur_tag  = req_addr[ADDR_W-1 -: TAG_W];
            cur_set  = req_addr[OFF_BITS +: SET_BITS];
            cur_word = req_addr[2 +: WORD_BITS];
        end else begin
            cur_tag  = addr_q[ADDR_W-1 -: TAG_W];
            cur_set  = addr_q[OFF_BITS +: SET_BITS];
            cur_word = addr_q[2 +: WORD_BITS];
        end
    end

    // Gather the indexed set's tags and flags
    always_comb begin
        for (int w = 0; w < WAYS; w++) way_tags[w] = tag_q[cur_set][w];
        valid_set = valid_q[cur_set];
        dirty_set = dirty_q[cur_set];
    end

    cache4w_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .way_tag   (way_tags),
        .way_valid (valid_set),
        .req_tag   (cur_tag),
        .hit_vec   (hit_vec),
        .hit_way   (hit_way)
    );

    assign lookup_hit = |hit_vec;
    assign req_ready  = (state == ST_IDLE);
    assign accept     = req_ready && req_valid;
    assign alloc      = accept && !lookup_hit && !(req_write && req_wthru);

    cache4w_victim #(.WAYS(WAYS)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_set (valid_set),
        .alloc     (alloc),
        .victim    (victim)
    );

    // Memory port drive per state
    always_comb begin
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_WB: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = {tag_q[cur_set][vway_q], cur_set, beat_q, 2'b00};
                mem_wdata = data_q[cur_set][vway_q][beat_q];
            end
            ST_FILL: begin
                mem_valid = 1'b1;
                mem_addr  = {cur_tag, cur_set, beat_q, 2'b00};
            end
            ST_WT: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = addr_q;
                mem_wdata = wdata_q;
            end
            default: ;
        endcase
    end

    // Sequencer, flags and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            addr_q     <= '0;
            wdata_q    <= '0;
            write_q    <= 1'b0;
            vway_q     <= '0;
            beat_q     <= '0;
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_rdata <= '0;
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else begin
            resp_valid <= 1'b0;
            case (state)
                ST_IDLE: if (accept) begin
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    write_q <= req_write;
                    if (lookup_hit) begin
                        resp_hit <= 1'b1;
                        if (!req_write) begin
                            resp_valid <= 1'b1;
                            resp_rdata <= data_q[cur_set][hit_way][cur_word];
                        end else if (req_wthru) begin
                            state <= ST_WT;
                        end else begin
                            resp_valid <= 1'b1;
                            dirty_q[cur_set][hit_way] <= 1'b1;
                        end
                    end else begin
                        resp_hit <= 1'b0;
                        beat_q   <= '0;
                        vway_q   <= victim;
                        if (req_write && req_wthru)
                            state <= ST_WT;
                        else if (valid_set[victim] && dirty_set[victim])
                            state <= ST_WB;
                        else
                            state <= ST_FILL;
                    end
                end
                ST_WB: if (mem_ack) begin
                    beat_q <= beat_q + 1'b1;
                    if (beat_q == LAST_BEAT) state <= ST_FILL;
                end
                ST_FILL: if (mem_ack) begin
                    beat_q <= beat_q + 1'b1;
                    if (beat_q == LAST_BEAT) begin
                        valid_q[cur_set][vway_q] <= 1'b1;
                        dirty_q[cur_set][vway_q] <= 1'b0;
                        state <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    resp_valid <= 1'b1;
                    state      <= ST_IDLE;
                    if (write_q) dirty_q[cur_set][vway_q] <= 1'b1;
                    else         resp_rdata <= data_q[cur_set][vway_q][cur_word];
                end
                ST_WT: if (mem_ack) begin
                    resp_valid <= 1'b1;
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Line data and tag updates (no reset: guarded by valid flags)
    always_ff @(posedge clk) begin
        if (accept && lookup_hit && req_write)
            data_q[cur_set][hit_way][cur_word] <= req_wdata;
        if (state == ST_FILL && mem_ack) begin
            data_q[cur_set][vway_q][beat_q] <= mem_rdata;
            if (beat_q == LAST_BEAT) tag_q[cur_set][vway_q] <= cur_tag;
        end
        if (state == ST_FIN && write_q)
            data_q[cur_set][vway_q][cur_word] <= wdata_q;
    end
endmodule

// File: rtl/cache4w_checker.sv
// Protocol and behaviour checks for cache4w_ctrl, attached by bind.
// Assumes the bound instance exposes hit_vec and lookup_hit.
module cache4w_checker #(
    parameter int WAYS   = 4,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_wthru,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              mem_valid,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic [WAYS-1:0]   hit_vec,
    input logic              lookup_hit
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !resp_valid && !mem_valid));

    assert_single_way_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    assert_read_hit_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write && lookup_hit) |=> (resp_valid && resp_hit));

    assert_cb_hit_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && !req_wthru && lookup_hit)
        |=> (resp_valid && resp_hit && !mem_valid));

    assert_wt_forward_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && req_wthru)
        |=> (mem_valid && mem_write && !req_ready));

    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready);

    assert_hold_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_addr)));
endmodule

bind cache4w_ctrl cache4w_checker #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_cache4w_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_wthru  (req_wthru),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .mem_valid  (mem_valid),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .hit_vec    (hit_vec),
    .lookup_hit (lookup_hit)
);

// File: tb/cache4w_ctrl_bench.sv
`timescale 1ns/1ps
// Scoreboard bench for cache4w_ctrl with four sets.
module cache4w_ctrl_bench;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_wthru = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, resp_valid, resp_hit;
    logic [DW-1:0] resp_rdata;
    logic          mem_valid, mem_write;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    cache4w_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SET_BITS(2), .WAYS(4), .LINE_WORDS(4)) u_cache4w_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_wthru(req_wthru),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #4 clk = ~clk;

    typedef struct {
        string       rq;
        logic        hit;
        logic        chk_data;
        logic [31:0] data;
    } exp_t;

    exp_t        expq[$];
    logic [32:0] mlog[$];
    logic [31:0] bmem [logic [31:0]];
    logic [31:0] refm [logic [31:0]];
    int n_chk = 0, n_err = 0, n_resp = 0;
    bit done = 0;

    function automatic logic [31:0] init_val(logic [31:0] a);
        return ~a ^ 32'h0F0F_0000;
    endfunction
    function automatic logic [31:0] bm_rd(logic [31:0] a);
        return bmem.exists(a) ? bmem[a] : init_val(a);
    endfunction
    function automatic logic [31:0] ref_rd(logic [31:0] a);
        return refm.exists(a) ? refm[a] : init_val(a);
    endfunction
    // tag above bit 6, set in bits [5:4], longword in bits [3:2]
    function automatic logic [31:0] ad(int t, int s, int w);
        return (32'(t) << 6) | (32'(s) << 4) | (32'(w) << 2);
    endfunction

    task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic chk_beat(string rq, int idx, bit wr, logic [31:0] a);
        if (idx < mlog.size()) chk(rq, "memory beat", 64'(mlog[idx]), 64'({wr, a}));
        else chk(rq, "memory beat missing", 64'(mlog.size()), 64'(idx + 1));
    endtask

    // Driver: push expectation, present request, wait for completion
    task automatic issue(string rq, bit wr, bit wt, logic [31:0] a, logic [31:0] d, bit exp_hit);
        exp_t e;
        int target;
        e.rq = rq; e.hit = exp_hit; e.chk_data = !wr; e.data = ref_rd(a);
        if (wr) refm[a] = d;
        while (!req_ready) @(negedge clk);
        mlog.delete();
        expq.push_back(e);
        target = n_resp + 1;
        req_valid = 1'b1; req_write = wr; req_wthru = wt; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (n_resp < target) @(negedge clk);
    endtask

    // Monitor: pop and compare each completion
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && resp_valid) begin
                if (expq.size() == 0) begin
                    chk("R3", "unexpected response", 64'(1), 64'(0));
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(e.rq, "hit flag", 64'(resp_hit), 64'(e.hit));
                    if (e.chk_data) chk(e.rq, "read data", 64'(resp_rdata), 64'(e.data));
                end
                n_resp++;
            end
        end
    end

    // Memory model: acknowledges every beat within one cycle
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (rst_n && mem_valid) begin
                mem_ack = 1'b1;
                if (mem_write) bmem[mem_addr] = mem_wdata;
                else mem_rdata = bm_rd(mem_addr);
                mlog.push_back({mem_write, mem_addr});
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk("R1", "ready", 64'(req_ready), 64'(1));
        chk("R1", "resp_valid", 64'(resp_valid), 64'(0));
        chk("R1", "mem_valid", 64'(mem_valid), 64'(0));

        // R6: read miss into empty set fills way 0 with four reads
        issue("R6", 0, 0, ad(1, 1, 2), 0, 0);
        chk("R6", "refill beats", 64'(mlog.size()), 64'(4));
        chk_beat("R6", 0, 0, ad(1, 1, 0));
        chk_beat("R6", 3, 0, ad(1, 1, 3));
        // R3: read hit on other longword of the line
        issue("R3", 0, 0, ad(1, 1, 3), 0, 1);
        // R2: same tag in another set misses
        issue("R2", 0, 0, ad(1, 2, 3), 0, 0);
        // R4: copyback write hit, no memory traffic
        issue("R4", 1, 0, ad(1, 1, 0), 32'hCAFE_0001, 1);
        chk("R4", "memory beats", 64'(mlog.size()), 64'(0));
        issue("R4", 0, 0, ad(1, 1, 0), 0, 1);
        // R7: fill remaining invalid ways of set 1
        issue("R7", 0, 0, ad(2, 1, 0), 0, 0);
        issue("R7", 0, 0, ad(3, 1, 0), 0, 0);
        issue("R7", 0, 0, ad(4, 1, 0), 0, 0);
        // R8: full set, pointer 0 picks dirty way 0: writeback then refill
        issue("R8", 0, 0, ad(5, 1, 1), 0, 0);
        chk("R8", "beats", 64'(mlog.size()), 64'(8));
        chk_beat("R8", 0, 1, ad(1, 1, 0));
        chk_beat("R8", 3, 1, ad(1, 1, 3));
        chk_beat("R8", 4, 0, ad(5, 1, 0));
        chk_beat("R8", 7, 0, ad(5, 1, 3));
        chk("R8", "written back data", 64'(bm_rd(ad(1, 1, 0))), 64'(32'hCAFE_0001));
        // R7: pointer moved to way 1 (clean), refetch evicted line
        issue("R7", 0, 0, ad(1, 1, 0), 0, 0);
        chk("R7", "clean victim beats", 64'(mlog.size()), 64'(4));
        // R10: hit among four valid ways returns the right line
        issue("R10", 0, 0, ad(5, 1, 1), 0, 1);
        // R5: write-through hit forwards one write
        issue("R5", 1, 1, ad(3, 1, 1), 32'h1234_5678, 1);
        chk("R5", "wt hit beats", 64'(mlog.size()), 64'(1));
        chk_beat("R5", 0, 1, ad(3, 1, 1));
        chk("R5", "memory data", 64'(bm_rd(ad(3, 1, 1))), 64'(32'h1234_5678));
        // R5: write-through miss, no allocation
        issue("R5", 1, 1, ad(6, 1, 0), 32'h0BAD_F00D, 0);
        chk("R5", "wt miss beats", 64'(mlog.size()), 64'(1));
        issue("R5", 0, 0, ad(6, 1, 0), 0, 0);
        chk("R5", "victim not modified by wt", 64'(mlog.size()), 64'(4));
        // R6: copyback write miss allocates way 3, merges
        issue("R6", 1, 0, ad(7, 1, 1), 32'h7777_0001, 0);
        chk("R6", "write miss beats", 64'(mlog.size()), 64'(4));
        chk_beat("R6", 0, 0, ad(7, 1, 0));
        issue("R6", 0, 0, ad(7, 1, 1), 0, 1);
        // R7: pointer wraps through ways 0..3; way 3 is modified
        issue("R7", 0, 0, ad(8, 1, 0), 0, 0);
        chk("R7", "way0 clean", 64'(mlog.size()), 64'(4));
        issue("R7", 0, 0, ad(9, 1, 0), 0, 0);
        chk("R7", "way1 clean", 64'(mlog.size()), 64'(4));
        issue("R7", 0, 0, ad(10, 1, 0), 0, 0);
        chk("R7", "way2 clean", 64'(mlog.size()), 64'(4));
        issue("R8", 0, 0, ad(11, 1, 2), 0, 0);
        chk("R8", "dirty wrap beats", 64'(mlog.size()), 64'(8));
        chk_beat("R8", 0, 1, ad(7, 1, 0));
        chk("R8", "merged data written back", 64'(bm_rd(ad(7, 1, 1))), 64'(32'h7777_0001));
        // R9: port is ready again once traffic ends
        chk("R9", "ready after traffic", 64'(req_ready), 64'(1));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule